// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style core. Each cycle it takes the working register, a second operand, an operation code and a bit index. It produces the 8-bit result and the next values of three status flags: zero, digit carry (carry out of the low nibble) and carry. The second operand is either the file-register operand or an 8-bit literal. For each flag the block also gives a write enable, because every operation touches only its own subset of the flags. The result goes back to the register file or the working register outside this block.

The block holds the three status flags in registers. On a rising clock edge with `exec_i` high, each flag whose write enable is set takes its next value. The other flags keep their stored values. The stored carry is the carry-in for add-with-carry, subtract-with-borrow and the rotates. Subtraction adds the complemented working register, so a carry of 1 means no borrow occurred.

Top module: `alu8_flags`

## Requirements
- R1: Operation code 0 (add) gives W + B mod 256, where B is the selected operand. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the result is 0. All three flag enables are set.
- R2: Operation code 1 (add with carry) gives W + B + C using the stored carry. Flags and enables are as in R1.
- R3: Operation code 2 (subtract) gives B + ~W + 1. C and DC are the carries out of bits 7 and 3, so C=1 means no borrow. Z tracks the result, and all three enables are set.
- R4: Operation code 3 (subtract with borrow) gives B + ~W + C using the stored carry. Flags and enables are as in R3.
- R5: These operations set only the Z enable, with Z set when the result is 0:
  - code 4: B+1
  - code 5: B-1
  - code 6: W&B
  - code 7: W|B
  - code 8: W^B
  - code 9: ~B
  - code 10: B
- R6: The shifts set the Z and C enables only. C receives the bit shifted out: bit 7 for a left shift, bit 0 for a right shift.
  - code 12: logical left, zero fill
  - code 13: logical right, zero fill
  - code 14: arithmetic right, bit 7 kept
- R7: The rotates go through the stored carry and set only the C enable. C receives the bit rotated out.
  - code 15: rotate left, C enters bit 0
  - code 16: rotate right, C enters bit 7
- R8: These operations set no flag enable. The bit index is 3 bits, 0 to 7.
  - code 17: exchange bits 3:0 with bits 7:4
  - code 18: set bit `bit_idx_i` of B
  - code 19: clear bit `bit_idx_i` of B
- R9: Operation code 11 (clear) gives 0, sets the Z enable and drives Z next to 1.
- R10: B is `lit_i` when `lit_sel_i` is 1 and `file_i` otherwise.
- R11: Reset, active low, clears all stored flags. On a rising edge with `exec_i` high, each flag whose enable is set takes its next value. A flag holds its value when its enable is clear or `exec_i` is low.
- R12: Operation codes 20 to 31 pass B through and set no flag enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset of the stored flags |
| exec_i | input | 1 | Commit enabled flags at this edge |
| op_i | input | 5 | Operation code |
| wreg_i | input | 8 | Working register value |
| file_i | input | 8 | File-register operand |
| lit_i | input | 8 | Literal operand |
| lit_sel_i | input | 1 | 1 selects the literal as operand B |
| bit_idx_i | input | 3 | Bit index for set and clear |
| res_o | output | 8 | Result, combinational |
| z_nx_o | output | 1 | Next zero flag |
| dc_nx_o | output | 1 | Next digit-carry flag |
| c_nx_o | output | 1 | Next carry flag |
| z_we_o | output | 1 | Zero flag write enable |
| dc_we_o | output | 1 | Digit-carry write enable |
| c_we_o | output | 1 | Carry write enable |
| z_o | output | 1 | Stored zero flag |
| dc_o | output | 1 | Stored digit-carry flag |
| c_o | output | 1 | Stored carry flag |

## Verification
The result, the next-flag values and the write enables are combinational. They are due in the same cycle as the inputs, so the bench applies the inputs on a falling edge and samples them a few nanoseconds later, before the next rising edge. The stored flags change one rising edge after a cycle with `exec_i` high. The bench therefore checks them at the falling edge that follows, against a bench-side flag model that is updated only for enabled flags. The same model supplies the carry-in that the bench uses when it computes each expected value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBB = 5'd3,
        OP_INC  = 5'd4,
        OP_DEC  = 5'd5,
        OP_AND  = 5'd6,
        OP_IOR  = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_MOV  = 5'd10,
        OP_CLR  = 5'd11,
        OP_LSL  = 5'd12,
        OP_LSR  = 5'd13,
        OP_ASR  = 5'd14,
        OP_RLC  = 5'd15,
        OP_RRC  = 5'd16,
        OP_SWAP = 5'd17,
        OP_BSET = 5'd18,
        OP_BCLR = 5'd19
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          half_co_o,
    output logic          co_o
);
    localparam int HALF = DW / 2;
    localparam int HB   = DW - HALF;

    logic [HALF:0] lo_sum;
    logic [HB:0]   hi_sum;

    // Split at the nibble boundary so the half carry falls out directly.
    always_comb begin
        lo_sum    = {1'b0, a_i[HALF-1:0]} + {1'b0, b_i[HALF-1:0]} + {{HALF{1'b0}}, cin_i};
        hi_sum    = {1'b0, a_i[DW-1:HALF]} + {1'b0, b_i[DW-1:HALF]} + {{HB{1'b0}}, lo_sum[HALF]};
        sum_o     = {hi_sum[HB-1:0], lo_sum[HALF-1:0]};
        half_co_o = lo_sum[HALF];
        co_o      = hi_sum[HB];
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int IDXW = $clog2(DW)
) (
    input  alu_op_e         op_i,
    input  logic [DW-1:0]   w_i,
    input  logic [DW-1:0]   opnd_i,
    input  logic            cin_i,
    input  logic [IDXW-1:0] idx_i,
    output logic [DW-1:0]   res_o,
    output logic            sout_o
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] mask;

    always_comb begin
        mask   = {{(DW-1){1'b0}}, 1'b1} << idx_i;
        res_o  = opnd_i;
        sout_o = 1'b0;
        case (op_i)
            OP_AND:  res_o = w_i & opnd_i;
            OP_IOR:  res_o = w_i | opnd_i;
            OP_XOR:  res_o = w_i ^ opnd_i;
            OP_COM:  res_o = ~opnd_i;
            OP_MOV:  res_o = opnd_i;
            OP_CLR:  res_o = '0;
            OP_LSL: begin
                res_o  = {opnd_i[DW-2:0], 1'b0};
                sout_o = opnd_i[DW-1];
            end
            OP_LSR: begin
                res_o  = {1'b0, opnd_i[DW-1:1]};
                sout_o = opnd_i[0];
            end
            OP_ASR: begin
                res_o  = {opnd_i[DW-1], opnd_i[DW-1:1]};
                sout_o = opnd_i[0];
            end
            OP_RLC: begin
                res_o  = {opnd_i[DW-2:0], cin_i};
                sout_o = opnd_i[DW-1];
            end
            OP_RRC: begin
                res_o  = {cin_i, opnd_i[DW-1:1]};
                sout_o = opnd_i[0];
            end
            OP_SWAP: res_o = {opnd_i[HALF-1:0], opnd_i[DW-1:HALF]};
            OP_BSET: res_o = opnd_i | mask;
            OP_BCLR: res_o = opnd_i & ~mask;
            default: res_o = opnd_i;
        endcase
    end
endmodule

// File: rtl/alu8_flagsel.sv
module alu8_flagsel
    import alu8_pkg::*;
(
    input  alu_op_e op_i,
    output flags_t  we_o,
    output logic    arith_o
);
    always_comb begin
        we_o    = '0;
        arith_o = 1'b0;
        case (op_i)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
                we_o    = '{z: 1'b1, dc: 1'b1, c: 1'b1};
                arith_o = 1'b1;
            end
            OP_INC, OP_DEC: begin
                we_o.z  = 1'b1;
                arith_o = 1'b1;
            end
            OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV, OP_CLR:
                we_o.z = 1'b1;
            OP_LSL, OP_LSR, OP_ASR: begin
                we_o.z = 1'b1;
                we_o.c = 1'b1;
            end
            OP_RLC, OP_RRC:
                we_o.c = 1'b1;
            default: we_o = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int IDXW = $clog2(DW)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            exec_i,
    input  logic [OPW-1:0]  op_i,
    input  logic [DW-1:0]   wreg_i,
    input  logic [DW-1:0]   file_i,
    input  logic [DW-1:0]   lit_i,
    input  logic            lit_sel_i,
    input  logic [IDXW-1:0] bit_idx_i,
    output logic [DW-1:0]   res_o,
    output logic            z_nx_o,
    output logic            dc_nx_o,
    output logic            c_nx_o,
    output logic            z_we_o,
    output logic            dc_we_o,
    output logic            c_we_o,
    output logic            z_o,
    output logic            dc_o,
    output logic            c_o
);
    alu_op_e       op;
    logic [DW-1:0] opnd;
    logic [DW-1:0] add_a, add_b, add_sum, bit_res;
    logic          add_cin, add_hco, add_co, bit_sout, is_arith;
    flags_t        we, nx, flg_d, flg_q;

    assign op   = alu_op_e'(op_i);
    assign opnd = lit_sel_i ? lit_i : file_i;

    // Adder input steering; subtraction is complement-and-add.
    always_comb begin
        add_a   = wreg_i;
        add_b   = opnd;
        add_cin = 1'b0;
        case (op)
            OP_ADDC: add_cin = flg_q.c;
            OP_SUB: begin
                add_a = opnd; add_b = ~wreg_i; add_cin = 1'b1;
            end
            OP_SUBB: begin
                add_a = opnd; add_b = ~wreg_i; add_cin = flg_q.c;
            end
            OP_INC: begin
                add_a = opnd; add_b = '0; add_cin = 1'b1;
            end
            OP_DEC: begin
                add_a = opnd; add_b = '1; add_cin = 1'b0;
            end
            default: ;
        endcase
    end

    alu8_adder #(.DW(DW)) u_add (
        .a_i(add_a), .b_i(add_b), .cin_i(add_cin),
        .sum_o(add_sum), .half_co_o(add_hco), .co_o(add_co)
    );

    alu8_bitops #(.DW(DW), .IDXW(IDXW)) u_bit (
        .op_i(op), .w_i(wreg_i), .opnd_i(opnd), .cin_i(flg_q.c),
        .idx_i(bit_idx_i), .res_o(bit_res), .sout_o(bit_sout)
    );

    alu8_flagsel u_sel (
        .op_i(op), .we_o(we), .arith_o(is_arith)
    );

    always_comb begin
        res_o = is_arith ? add_sum : bit_res;
        nx.z  = (res_o == '0);
        nx.dc = add_hco;
        nx.c  = is_arith ? add_co : bit_sout;
    end

    // Next-state process for the stored flags.
    always_comb begin
        flg_d = flg_q;
        if (exec_i) begin
            if (we.z)  flg_d.z  = nx.z;
            if (we.dc) flg_d.dc = nx.dc;
            if (we.c)  flg_d.c  = nx.c;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) flg_q <= '0;
        else         flg_q <= flg_d;
    end

    assign z_nx_o  = nx.z;
    assign dc_nx_o = nx.dc;
    assign c_nx_o  = nx.c;
    assign z_we_o  = we.z;
    assign dc_we_o = we.dc;
    assign c_we_o  = we.c;
    assign z_o     = flg_q.z;
    assign dc_o    = flg_q.dc;
    assign c_o     = flg_q.c;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       exec_i,
    input logic [4:0] op_i,
    input logic [7:0] file_i,
    input logic [7:0] lit_i,
    input logic       lit_sel_i,
    input logic [7:0] res_o,
    input logic       z_nx_o,
    input logic       dc_nx_o,
    input logic       c_nx_o,
    input logic       z_we_o,
    input logic       dc_we_o,
    input logic       c_we_o,
    input logic       z_o,
    input logic       dc_o,
    input logic       c_o
);
    logic [7:0] b_sel;
    assign b_sel = lit_sel_i ? lit_i : file_i;

    a_r11_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exec_i |=> $stable({z_o, dc_o, c_o}));

    a_r11_carry_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && c_we_o) |=> (c_o == $past(c_nx_o)));

    a_r11_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && !z_we_o) |=> $stable(z_o));

    a_r5_zero_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i >= 5'd4 && op_i <= 5'd10) |-> (z_we_o && !dc_we_o && !c_we_o));

    a_r6_left_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 5'd12) |-> (c_we_o && z_we_o && c_nx_o == b_sel[7]));

    a_r7_rot_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 5'd15 || op_i == 5'd16) |-> (c_we_o && !z_we_o && !dc_we_o));

    a_r8_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i >= 5'd17 && op_i <= 5'd19) |-> !(z_we_o || dc_we_o || c_we_o));

    a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 5'd11) |-> (res_o == 8'd0 && z_we_o && z_nx_o));

    a_r12_unused_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i >= 5'd20) |-> (res_o == b_sel && !(z_we_o || dc_we_o || c_we_o)));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .op_i(op_i),
    .file_i(file_i), .lit_i(lit_i), .lit_sel_i(lit_sel_i), .res_o(res_o),
    .z_nx_o(z_nx_o), .dc_nx_o(dc_nx_o), .c_nx_o(c_nx_o),
    .z_we_o(z_we_o), .dc_we_o(dc_we_o), .c_we_o(c_we_o),
    .z_o(z_o), .dc_o(dc_o), .c_o(c_o)
);

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec = 1'b0;
    logic [4:0] op = '0;
    logic [7:0] wreg = '0, fil = '0, lit = '0;
    logic       lsel = 1'b0;
    logic [2:0] idx = '0;
    logic [7:0] res;
    logic       znx, dcnx, cnx, zwe, dcwe, cwe, zq, dcq, cq;

    int n_run = 0;
    int n_fail = 0;
    logic mz = 1'b0, mdc = 1'b0, mc = 1'b0;

    always #10 clk = ~clk;

    alu8_flags dut_i (
        .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op),
        .wreg_i(wreg), .file_i(fil), .lit_i(lit), .lit_sel_i(lsel),
        .bit_idx_i(idx), .res_o(res), .z_nx_o(znx), .dc_nx_o(dcnx),
        .c_nx_o(cnx), .z_we_o(zwe), .dc_we_o(dcwe), .c_we_o(cwe),
        .z_o(zq), .dc_o(dcq), .c_o(cq)
    );

    function automatic string tag_of(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4, 5, 6, 7, 8, 9, 10: return "R5";
            11: return "R9";
            12, 13, 14: return "R6";
            15, 16: return "R7";
            17, 18, 19: return "R8";
            default: return "R12";
        endcase
    endfunction

    // Reference: {res[7:0], z, dc, c, zwe, dcwe, cwe}
    function automatic logic [13:0] ref_model(input int o, input int w, input int b,
                                               input int c, input int k);
        int r = b, z_e = 0, d_e = 0, c_e = 0, fc = 0, fd = 0;
        case (o)
            0, 1: begin
                r  = w + b + (o == 1 ? c : 0);
                fd = ((w % 16) + (b % 16) + (o == 1 ? c : 0)) >= 16;
                fc = r >= 256; z_e = 1; d_e = 1; c_e = 1;
            end
            2, 3: begin
                r  = b + (255 - w) + (o == 2 ? 1 : c);
                fd = ((b % 16) + (15 - (w % 16)) + (o == 2 ? 1 : c)) >= 16;
                fc = r >= 256; z_e = 1; d_e = 1; c_e = 1;
            end
            4:  begin r = b + 1;   z_e = 1; end
            5:  begin r = b + 255; z_e = 1; end
            6:  begin r = w & b;   z_e = 1; end
            7:  begin r = w | b;   z_e = 1; end
            8:  begin r = w ^ b;   z_e = 1; end
            9:  begin r = 255 - b; z_e = 1; end
            10: begin r = b;       z_e = 1; end
            11: begin r = 0;       z_e = 1; end
            12: begin r = b * 2;   fc = b / 128; z_e = 1; c_e = 1; end
            13: begin r = b / 2;   fc = b % 2;   z_e = 1; c_e = 1; end
            14: begin r = b / 2 + (b & 128); fc = b % 2; z_e = 1; c_e = 1; end
            15: begin r = b * 2 + c;         fc = b / 128; c_e = 1; end
            16: begin r = b / 2 + c * 128;   fc = b % 2;   c_e = 1; end
            17: r = (b % 16) * 16 + b / 16;
            18: r = b | (1 << k);
            19: r = b & (255 - (1 << k));
            default: r = b;
        endcase
        r = r % 256;
        return {r[7:0], (r == 0) ? 1'b1 : 1'b0, fd[0], fc[0], z_e[0], d_e[0], c_e[0]};
    endfunction

    task automatic check(input string what, input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int o, input int w, input int f, input int l,
                        input logic ls, input int k, input logic ex);
        logic [13:0] e;
        string t;
        @(negedge clk);
        // Stored flags reflect the previous step's commit (R11).
        check("stored flags", "R11", {zq, dcq, cq}, {mz, mdc, mc});
        op = o[4:0]; wreg = w[7:0]; fil = f[7:0]; lit = l[7:0];
        lsel = ls; idx = k[2:0]; exec = ex;
        #5;
        e = ref_model(o, w, ls ? l : f, mc, k);
        t = ls ? {tag_of(o), "/R10"} : tag_of(o);
        check("result", t, res, e[13:6]);
        check("enables", t, {zwe, dcwe, cwe}, e[2:0]);
        if (e[2]) check("z next", t, znx, e[5]);
        if (e[1]) check("dc next", t, dcnx, e[4]);
        if (e[0]) check("c next", t, cnx, e[3]);
        if (ex) begin
            if (e[2]) mz  = e[5];
            if (e[1]) mdc = e[4];
            if (e[0]) mc  = e[3];
        end
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("reset flags", "R11", {zq, dcq, cq}, 3'b000);
        rst_n = 1'b1;
        // Directed corners
        step(0, 8'hFF, 8'h01, 0, 1'b0, 0, 1'b1);   // R1 wrap: 0, C, DC, Z
        step(1, 8'h10, 8'h20, 0, 1'b0, 0, 1'b1);   // R2 with carry in 1
        step(2, 8'h05, 8'h05, 0, 1'b0, 0, 1'b1);   // R3 equal: Z, no borrow
        step(2, 8'h05, 8'h03, 0, 1'b0, 0, 1'b1);   // R3 borrow: C=0
        step(3, 8'h01, 8'h10, 0, 1'b0, 0, 1'b1);   // R4 with borrow in
        step(14, 0, 8'h81, 0, 1'b0, 0, 1'b1);      // R6 arith right keeps bit 7
        step(16, 0, 8'h02, 0, 1'b0, 0, 1'b1);      // R7 rotate right carry in
        step(18, 0, 0, 8'h00, 1'b1, 7, 1'b1);      // R8 bit 7 set, R10 literal
        step(11, 8'h3C, 8'h5A, 0, 1'b0, 0, 1'b1);  // R9 clear
        step(25, 8'h11, 8'hA5, 0, 1'b0, 0, 1'b1);  // R12 unused code
        step(12, 0, 8'hFF, 0, 1'b0, 0, 1'b0);      // R11 no commit when idle
        // Constrained random
        for (int i = 0; i < 600; i++)
            step($urandom_range(0, 23), $urandom_range(0, 255), $urandom_range(0, 255),
                 $urandom_range(0, 255), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 7), 1'($urandom_range(0, 3) != 0));
        step(10, 0, 0, 0, 1'b0, 0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule